// File: doc/BRIEF.md
# Loop Count-and-Branch Unit

This unit carries out a single loop-control instruction. The instruction counts a register up or down, or only tests it. It then branches or falls through depending on whether the register is zero. A control byte chooses three things: the step (decrement, increment or test only), the branch sense (branch on zero or branch on nonzero) and one of eight registers. The same byte also supplies the sign of a 9-bit displacement. The fetched displacement byte supplies the other eight bits. Registers 0 to 3 are byte-wide (accumulator A, accumulator B, condition codes, scratch). Registers 4 to 7 are word-wide (D, X, Y, stack pointer).

The sequencer accepts a `start` pulse together with the control byte, the displacement byte and the program counter. That program counter is the address already past the displacement byte. The unit then walks four named states. In IDLE it waits for `start`, and IDLE->READ is taken when `start` is high. READ->EVAL always follows, and in READ the operand is read from the register-file port selected by `rf_rd_sel`. In EVAL the new value, the zero flag, the branch decision and the target are computed and held, and EVAL->COMMIT always follows. In COMMIT the outputs are presented for one cycle with `done` high, and COMMIT->IDLE always follows. `busy` is high in READ, EVAL and COMMIT, and `start` is ignored in those states.

Top module: `loop_branch_unit`

## Requirements
- R1: After reset `done`, `busy`, `rf_wr_en` and `br_taken` are all 0.
- R2: Control byte bits 7:6 = 00 decrements the selected register and writes the result back.
- R3: Control byte bits 7:6 = 10 increments the selected register and writes the result back.
- R4: Control byte bits 7:6 = 01 or 11 only tests the register: `rf_wr_en` stays 0 for the whole instruction, so the register is unchanged.
- R5: For registers 0 to 3 (byte-wide), the step wraps within 8 bits, the written value has its upper byte zero, and the zero test looks only at the low 8 bits.
- R6: For registers 4 to 7, the step and the zero test use all 16 bits, wrapping modulo 2^16.
- R7: Control byte bit 5 = 1 branches when the resulting value is nonzero; bit 5 = 0 branches when it is zero. `br_taken` reports the decision.
- R8: When taken, `pc_out` = `pc_in` + sign-extended {bit 4, displacement byte}, modulo 2^16; when not taken, `pc_out` = `pc_in`.
- R9: `done` is a single-cycle pulse in the third clock after the edge that accepts `start`. `start` is ignored while `busy` is 1.
- R10: The register written (`rf_wr_sel`) and the register read (`rf_rd_sel`) are both control byte bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (accepted in IDLE only) |
| ctrl_byte | input | 8 | Step, branch sense, displacement sign, register index |
| disp_byte | input | 8 | Low 8 bits of the displacement |
| pc_in | input | 16 | Address following the displacement byte |
| rf_rd_sel | output | 3 | Register-file read index |
| rf_rd_data | input | 16 | Register-file read data (byte registers in bits 7:0) |
| rf_wr_en | output | 1 | Register writeback strobe |
| rf_wr_sel | output | 3 | Register-file write index |
| rf_wr_data | output | 16 | Value written back |
| br_taken | output | 1 | Branch decision, valid with `done` |
| pc_out | output | 16 | Next program counter, valid with `done` |
| done | output | 1 | Instruction complete |
| busy | output | 1 | Instruction in flight |

## Verification
A state register stuck outside IDLE would show as `busy` staying high and later `start` pulses being dropped. That is visible within one instruction, since `done` would fail to appear exactly three clocks after acceptance. A wrongly latched control field would show in the COMMIT cycle itself as a wrong `rf_wr_sel`, a write strobe during a test-only step, or a branch sense inverted on the zero and nonzero vectors. A bad sign or width choice shows the same way as a target off by 256 or a byte-register result with a nonzero upper byte. A corrupted operand capture surfaces as a wrong `rf_wr_data` in that same COMMIT cycle.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_EVAL   = 2'd2,
        ST_COMMIT = 2'd3
    } lbu_state_e;

    typedef enum logic [1:0] {
        STEP_DEC  = 2'b00,
        STEP_TEST = 2'b01,
        STEP_INC  = 2'b10,
        STEP_TSTX = 2'b11
    } lbu_step_e;

    typedef struct packed {
        lbu_step_e  step;
        logic       on_nonzero;
        logic       disp_sign;
        logic [2:0] sel;
        logic       narrow;
    } lbu_ctrl_t;

endpackage

// File: rtl/lbu_decode.sv
module lbu_decode
    import lbu_pkg::*;
#(
    parameter int CTRL_W       = 8,
    parameter int NARROW_LIMIT = 4
) (
    input  logic [CTRL_W-1:0] ctrl_byte,
    output lbu_ctrl_t         fields
);
    localparam int STEP_HI = CTRL_W - 1;
    localparam int STEP_LO = CTRL_W - 2;
    localparam int SENSE_B = 5;
    localparam int SIGN_B  = 4;

    always_comb begin
        fields.step       = lbu_step_e'(ctrl_byte[STEP_HI:STEP_LO]);
        fields.on_nonzero = ctrl_byte[SENSE_B];
        fields.disp_sign  = ctrl_byte[SIGN_B];
        fields.sel        = ctrl_byte[2:0];
        fields.narrow     = (32'(ctrl_byte[2:0]) < NARROW_LIMIT);
    end

endmodule

// File: rtl/lbu_step.sv
module lbu_step
    import lbu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  lbu_step_e         step,
    input  logic              narrow,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result,
    output logic              writes,
    output logic              is_zero
);
    localparam int HI_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0] delta;
    logic [DATA_W-1:0] stepped;

    always_comb begin
        unique case (step)
            STEP_DEC: delta = '1;
            STEP_INC: delta = DATA_W'(1);
            default:  delta = '0;
        endcase
        stepped = operand + delta;
        writes  = (step == STEP_DEC) || (step == STEP_INC);
        if (narrow) begin
            result  = {{HI_W{1'b0}}, stepped[NARROW_W-1:0]};
            is_zero = (stepped[NARROW_W-1:0] == '0);
        end else begin
            result  = stepped;
            is_zero = (stepped == '0);
        end
    end

endmodule

// File: rtl/lbu_target.sv
module lbu_target #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 9
) (
    input  logic [PC_W-1:0]   pc_base,
    input  logic              disp_sign,
    input  logic [DISP_W-2:0] disp_low,
    output logic [PC_W-1:0]   target
);
    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] offset;

    generate
        if (EXT_W > 0) begin : g_ext
            assign offset = {{EXT_W{disp_sign}}, disp_sign, disp_low};
        end else begin : g_trunc
            assign offset = PC_W'({disp_sign, disp_low});
        end
    endgenerate

    assign target = pc_base + offset;

endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
    import lbu_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int PC_W         = 16,
    parameter int NARROW_W     = 8,
    parameter int NARROW_LIMIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        ctrl_byte,
    input  logic [7:0]        disp_byte,
    input  logic [PC_W-1:0]   pc_in,
    output logic [2:0]        rf_rd_sel,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [2:0]        rf_wr_sel,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              br_taken,
    output logic [PC_W-1:0]   pc_out,
    output logic              done,
    output logic              busy
);
    localparam int DISP_W = 9;

    lbu_state_e        state_q, state_d;
    lbu_ctrl_t         ctrl_dec, ctrl_q;
    logic [7:0]        disp_q;
    logic [PC_W-1:0]   pc_q;
    logic [DATA_W-1:0] operand_q;
    logic [DATA_W-1:0] result_q;
    logic              write_q;
    logic              taken_q;
    logic [PC_W-1:0]   target_q;

    logic [DATA_W-1:0] step_result;
    logic              step_writes;
    logic              step_zero;
    logic [PC_W-1:0]   branch_target;
    logic              branch_cond;

    lbu_decode #(.CTRL_W(8), .NARROW_LIMIT(NARROW_LIMIT)) u_decode (
        .ctrl_byte (ctrl_byte),
        .fields    (ctrl_dec)
    );

    lbu_step #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_step (
        .step    (ctrl_q.step),
        .narrow  (ctrl_q.narrow),
        .operand (operand_q),
        .result  (step_result),
        .writes  (step_writes),
        .is_zero (step_zero)
    );

    lbu_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_target (
        .pc_base   (pc_q),
        .disp_sign (ctrl_q.disp_sign),
        .disp_low  (disp_q),
        .target    (branch_target)
    );

    assign branch_cond = ctrl_q.on_nonzero ? !step_zero : step_zero;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_READ;
            ST_READ:   state_d = ST_EVAL;
            ST_EVAL:   state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            disp_q    <= '0;
            pc_q      <= '0;
            operand_q <= '0;
            result_q  <= '0;
            write_q   <= 1'b0;
            taken_q   <= 1'b0;
            target_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ctrl_q <= ctrl_dec;
                        disp_q <= disp_byte;
                        pc_q   <= pc_in;
                    end
                end
                ST_READ: begin
                    operand_q <= rf_rd_data;
                end
                ST_EVAL: begin
                    result_q <= step_result;
                    write_q  <= step_writes;
                    taken_q  <= branch_cond;
                    target_q <= branch_cond ? branch_target : pc_q;
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        rf_rd_sel  = ctrl_q.sel;
        rf_wr_sel  = ctrl_q.sel;
        rf_wr_data = result_q;
        pc_out     = target_q;
        busy       = (state_q != ST_IDLE);
        done       = 1'b0;
        rf_wr_en   = 1'b0;
        br_taken   = 1'b0;
        unique case (state_q)
            ST_COMMIT: begin
                done     = 1'b1;
                rf_wr_en = write_q;
                br_taken = taken_q;
            end
            default: begin
            end
        endcase
    end

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: once busy, stays busy until done
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R4: writeback only in the completion cycle
    a_r4_write_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> done);
    // R7: branch flag only with done
    a_r7_taken_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> done);
    // R5: byte registers written with zero upper byte
    a_r5_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en && (32'(rf_wr_sel) < NARROW_LIMIT)) |-> (rf_wr_data[DATA_W-1:NARROW_W] == '0));
    // R10: written register is the one read
    a_r10_same_reg: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (rf_wr_sel == rf_rd_sel));
    // R8: fall-through keeps the incoming PC
    a_r8_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !br_taken) |-> (pc_out == pc_q));

endmodule

// File: tb/loop_branch_unit_bench.sv
module loop_branch_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  ctrl_byte = '0;
    logic [7:0]  disp_byte = '0;
    logic [15:0] pc_in = '0;
    logic [2:0]  rf_rd_sel;
    logic [15:0] rf_rd_data = '0;
    logic        rf_wr_en;
    logic [2:0]  rf_wr_sel;
    logic [15:0] rf_wr_data;
    logic        br_taken;
    logic [15:0] pc_out;
    logic        done;
    logic        busy;

    int checks = 0;
    int failures = 0;
    int wr_count = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    loop_branch_unit u_loop_branch_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .ctrl_byte(ctrl_byte),
        .disp_byte(disp_byte), .pc_in(pc_in), .rf_rd_sel(rf_rd_sel),
        .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_sel(rf_wr_sel),
        .rf_wr_data(rf_wr_data), .br_taken(br_taken), .pc_out(pc_out),
        .done(done), .busy(busy)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rf_wr_en) wr_count <= wr_count + 1;
    end

    typedef struct packed {
        logic [7:0]  cb;
        logic [7:0]  db;
        logic [15:0] pc;
        logic [15:0] rv;
        logic        ew;
        logic [15:0] ed;
        logic        et;
        logic [15:0] ep;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TABLE [NV] = '{
        '{8'h04, 8'h10, 16'h1000, 16'h0001, 1'b1, 16'h0000, 1'b1, 16'h1010}, // R2 R6 R7 zero
        '{8'h24, 8'h10, 16'h1000, 16'h0001, 1'b1, 16'h0000, 1'b0, 16'h1000}, // R7 nz not taken
        '{8'h30, 8'hF0, 16'h1000, 16'h0000, 1'b1, 16'h00FF, 1'b1, 16'h0FF0}, // R5 wrap, R8 negative
        '{8'h81, 8'h7F, 16'h1000, 16'hAAFF, 1'b1, 16'h0000, 1'b1, 16'h107F}, // R3 R5 byte wrap
        '{8'h45, 8'h02, 16'h1000, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h1002}, // R4 test
        '{8'h65, 8'h02, 16'h1000, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h1000}, // R4 test nz
        '{8'hB7, 8'h40, 16'h1000, 16'hFFFF, 1'b1, 16'h0000, 1'b0, 16'h1000}, // R3 R6 word wrap
        '{8'hA6, 8'h80, 16'hFFF0, 16'h1234, 1'b1, 16'h1235, 1'b1, 16'h0070}, // R8 pc wrap
        '{8'h32, 8'h00, 16'h1000, 16'h0005, 1'b1, 16'h0004, 1'b1, 16'h0F00}, // R8 -256
        '{8'hC3, 8'h05, 16'h1000, 16'h0100, 1'b0, 16'h0000, 1'b1, 16'h1005}, // R4 R5 low-byte zero test
        '{8'h04, 8'h10, 16'h1000, 16'h0000, 1'b1, 16'hFFFF, 1'b0, 16'h1000}  // R2 R6 word borrow
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input vec_t v);
        int w0;
        @(negedge clk);
        ctrl_byte = v.cb; disp_byte = v.db; pc_in = v.pc; rf_rd_data = v.rv;
        start = 1'b1;
        w0 = wr_count;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R10 rd_sel", 16'(rf_rd_sel), 16'(v.cb[2:0]));
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R9 done", 16'(done), 16'd1);
        check("R4 wr_en", 16'(rf_wr_en), 16'(v.ew));
        if (v.ew) begin
            check("R2/R3 R5 R6 wr_data", rf_wr_data, v.ed);
            check("R10 wr_sel", 16'(rf_wr_sel), 16'(v.cb[2:0]));
        end
        check("R7 taken", 16'(br_taken), 16'(v.et));
        check("R8 pc_out", pc_out, v.ep);
        @(posedge clk);
        @(negedge clk);
        check("R9 done pulse", 16'(done), 16'd0);
        check("R4 write count", 16'(wr_count - w0), v.ew ? 16'd1 : 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 done", 16'(done), 16'd0);
        check("R1 busy", 16'(busy), 16'd0);
        check("R1 wr_en", 16'(rf_wr_en), 16'd0);
        check("R1 taken", 16'(br_taken), 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", 16'(busy), 16'd0);

        for (int i = 0; i < NV; i++) run(TABLE[i]);

        // R9: start while busy is ignored
        @(negedge clk);
        ctrl_byte = 8'h85; disp_byte = 8'h00; pc_in = 16'h2000; rf_rd_data = 16'h00FF;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9 busy", 16'(busy), 16'd1);
        ctrl_byte = 8'h02; pc_in = 16'h3000; // start still high: must be ignored
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R9 done", 16'(done), 16'd1);
        check("R9 first wr_sel kept", 16'(rf_wr_sel), 16'd5);
        check("R3 first data kept", rf_wr_data, 16'h0100);
        check("R9 first pc kept", pc_out, 16'h2000);
        @(posedge clk);
        @(negedge clk);
        check("R9 idle again", 16'(busy), 16'd0);
        repeat (3) @(negedge clk);
        check("R9 no restart", 16'(busy), 16'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles >= 5000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=<5000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule